// File: doc/BRIEF.md
# Receive Frame Size Check and Statistics Bank

This block sits behind the receive filter of an Ethernet MAC. For every finished frame it gets the frame length, a destination class code and a one-cycle done strobe. It applies the oversize rule, using a long-frame enable and a keep-bad-frames control. It reports a drop decision. It then updates a bank of saturating statistics counters.

The bank holds the following counters:
- six length histogram bins;
- a total-frames counter and a good-frames counter;
- wide total-octet and good-octet counters;
- a broadcast counter and a multicast counter;
- an oversize-drop counter.

Software reads the counters through a 4-bit address and 32-bit data read port. Each octet counter is read as a low word and a high word. A synchronous clear zeros every counter.

Top module: `rx_stat_bank`

## Requirements
- R1: A frame is oversized when its length exceeds 16384, or when it exceeds 1522 while `long_en_i` is 0. A frame of exactly 1522 (long frames off) or exactly 16384 (long frames on) is not oversized.
- R2: An oversized frame with `keep_bad_i` = 0 is dropped. `drop_o` is 1 for exactly the cycle after the strobe. Only the oversize counter (address 14) increments for a dropped frame. `drop_o` is 0 after any cycle without a strobe.
- R3: With `keep_bad_i` = 1, an oversized frame is not dropped. It is counted like any accepted frame, and the oversize counter is unchanged.
- R4: An accepted frame increments one histogram bin, read at addresses 0 to 5:
  - address 0: length exactly 64;
  - address 1: length 65 to 127;
  - address 2: length 128 to 255;
  - address 3: length 256 to 511;
  - address 4: length 512 to 1023;
  - address 5: length above 1023.
  A frame shorter than 64 bytes increments no bin.
- R5: Every accepted frame increments both the total-frames counter (address 6) and the good-frames counter (address 7).
- R6: Every accepted frame adds its length plus 4 to the total-octet counter and to the good-octet counter. The total-octet counter is read as a low word at address 8 and a high word at address 9. The good-octet counter is read as a low word at address 10 and a high word at address 11.
- R7: Class code 2'b10 is broadcast and increments address 12. Class code 2'b01 is multicast and increments address 13. Codes 2'b00 and 2'b11 are unicast and increment neither.
- R8: No counter wraps. An increment that would pass the counter's maximum leaves the counter at all ones.
- R9: With `clr_i` high at a clock edge, every counter reads 0 after that edge, even when a strobe arrives in the same cycle. `drop_o` still follows R2.
- R10: Address 15 reads 0. Counter state is seen on `rd_data_o` in the cycle after the strobe's edge.
- R11: During reset, every address reads 0 and `drop_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all counters |
| frm_done_i | input | 1 | One-cycle strobe for a finished frame |
| frm_len_i | input | LEN_W | Frame length in bytes, without FCS |
| frm_class_i | input | 2 | 00/11 unicast, 01 multicast, 10 broadcast |
| long_en_i | input | 1 | Raises the size limit from 1522 to 16384 |
| keep_bad_i | input | 1 | Accept oversized frames instead of dropping them |
| rd_addr_i | input | 4 | Counter read address |
| rd_data_o | output | 32 | Read data, zero-extended counter value |
| drop_o | output | 1 | Frame dropped, one cycle after its strobe |

## Verification
The assertions check the following on every cycle:
- the drop pulse timing for each combination of size and control bits;
- the absence of spurious drops;
- that every address reads zero right after a clear;
- that a steadily addressed non-low-word counter never decreases, which rules out wrap-around.

Only the bench's scenarios show the exact bin chosen at each length edge, the plus-four octet arithmetic, the split between broadcast and multicast, and the exact point of saturation. The bench builds the block with narrow counters, so saturation is reached in a few thousand cycles.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int NUM_BINS = 6;
  localparam int NUM_CTR  = 11;  // bins, total, good, bcast, mcast, oversize

  localparam int CI_TOT  = 6;
  localparam int CI_GOOD = 7;
  localparam int CI_BC   = 8;
  localparam int CI_MC   = 9;
  localparam int CI_OVR  = 10;

  localparam logic [1:0] CLS_MCAST = 2'b01;
  localparam logic [1:0] CLS_BCAST = 2'b10;

  localparam logic [3:0] RA_TOCT_LO = 4'd8;
  localparam logic [3:0] RA_TOCT_HI = 4'd9;
  localparam logic [3:0] RA_GOCT_LO = 4'd10;
  localparam logic [3:0] RA_GOCT_HI = 4'd11;
  localparam logic [3:0] RA_BC      = 4'd12;
  localparam logic [3:0] RA_MC      = 4'd13;
  localparam logic [3:0] RA_OVR     = 4'd14;
endpackage

// File: rtl/rx_sat_ctr.sv
module rx_sat_ctr #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   sum;

  assign sum   = {1'b0, cnt_q} + (W+1)'(inc_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/rx_size_class.sv
module rx_size_class #(
  parameter int LEN_W     = 16,
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 16384,
  parameter int NUM_BINS  = 6,
  parameter int BASE      = 64
) (
  input  logic [LEN_W-1:0]    len_i,
  input  logic                long_en_i,
  output logic                oversize_o,
  output logic [NUM_BINS-1:0] bin_o
);
  assign oversize_o = (len_i > LEN_W'(JUMBO_MAX)) ||
                      (!long_en_i && (len_i > LEN_W'(STD_MAX)));

  assign bin_o[0] = (len_i == LEN_W'(BASE));

  for (genvar k = 1; k < NUM_BINS; k++) begin : g_bin
    localparam int LO = (k == 1) ? BASE + 1 : (BASE / 2) << k;
    localparam int HI = (BASE << k) - 1;
    if (k == NUM_BINS - 1) begin : g_top
      assign bin_o[k] = (len_i >= LEN_W'(LO));
    end else begin : g_mid
      assign bin_o[k] = (len_i >= LEN_W'(LO)) && (len_i <= LEN_W'(HI));
    end
  end
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
  import rx_stat_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 32,
  parameter int OCT_W     = 64,
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 16384,
  parameter int FCS_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             frm_done_i,
  input  logic [LEN_W-1:0] frm_len_i,
  input  logic [1:0]       frm_class_i,
  input  logic             long_en_i,
  input  logic             keep_bad_i,
  input  logic [3:0]       rd_addr_i,
  output logic [31:0]      rd_data_o,
  output logic             drop_o
);
  localparam int INC_W = LEN_W + 1;

  logic                oversize;
  logic [NUM_BINS-1:0] bin_hit;
  logic                drop_now, accept;
  logic [NUM_CTR-1:0]  ctr_en;
  logic [INC_W-1:0]    oct_inc;
  logic [CNT_W-1:0]    cnt_q [NUM_CTR];
  logic [OCT_W-1:0]    oct_q [2];
  logic [31:0]         pkt_ext [NUM_CTR];
  logic [63:0]         oct_ext [2];

  rx_size_class #(
    .LEN_W(LEN_W), .STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX), .NUM_BINS(NUM_BINS)
  ) u_cls (
    .len_i(frm_len_i), .long_en_i(long_en_i), .oversize_o(oversize), .bin_o(bin_hit)
  );

  assign drop_now = frm_done_i && oversize && !keep_bad_i;
  assign accept   = frm_done_i && !drop_now;
  assign oct_inc  = INC_W'(frm_len_i) + INC_W'(FCS_BYTES);

  always_comb begin
    ctr_en = '0;
    ctr_en[NUM_BINS-1:0] = accept ? bin_hit : '0;
    ctr_en[CI_TOT]  = accept;
    ctr_en[CI_GOOD] = accept;
    ctr_en[CI_BC]   = accept && (frm_class_i == CLS_BCAST);
    ctr_en[CI_MC]   = accept && (frm_class_i == CLS_MCAST);
    ctr_en[CI_OVR]  = drop_now;
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_pkt
    rx_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ctr (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(ctr_en[i]),
      .inc_i(1'b1), .cnt_o(cnt_q[i])
    );
  end

  // index 0: total octets, 1: good octets
  for (genvar j = 0; j < 2; j++) begin : g_oct
    rx_sat_ctr #(.W(OCT_W), .INC_W(INC_W)) u_ctr (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(accept),
      .inc_i(oct_inc), .cnt_o(oct_q[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_o <= 1'b0;
    else         drop_o <= drop_now;
  end

  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) begin
      pkt_ext[i] = '0;
      pkt_ext[i][CNT_W-1:0] = cnt_q[i];
    end
    for (int j = 0; j < 2; j++) begin
      oct_ext[j] = '0;
      oct_ext[j][OCT_W-1:0] = oct_q[j];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < 4'(CI_BC)) rd_data_o = pkt_ext[rd_addr_i];
    else begin
      case (rd_addr_i)
        RA_TOCT_LO: rd_data_o = oct_ext[0][31:0];
        RA_TOCT_HI: rd_data_o = oct_ext[0][63:32];
        RA_GOCT_LO: rd_data_o = oct_ext[1][31:0];
        RA_GOCT_HI: rd_data_o = oct_ext[1][63:32];
        RA_BC:      rd_data_o = pkt_ext[CI_BC];
        RA_MC:      rd_data_o = pkt_ext[CI_MC];
        RA_OVR:     rd_data_o = pkt_ext[CI_OVR];
        default:    rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_stat_bank_chk.sv
module rx_stat_bank_chk
  import rx_stat_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 16384
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             frm_done_i,
  input logic [LEN_W-1:0] frm_len_i,
  input logic             long_en_i,
  input logic             keep_bad_i,
  input logic [3:0]       rd_addr_i,
  input logic [31:0]      rd_data_o,
  input logic             drop_o
);
  logic too_big;
  assign too_big = (frm_len_i > LEN_W'(JUMBO_MAX)) ||
                   (!long_en_i && (frm_len_i > LEN_W'(STD_MAX)));

  a_r2_drop_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done_i && !keep_bad_i && too_big) |=> drop_o);

  a_r3_keep_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done_i && (keep_bad_i || !too_big)) |=> !drop_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_done_i |=> !drop_o);

  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rd_data_o == '0));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && rd_addr_i != RA_TOCT_LO && rd_addr_i != RA_GOCT_LO)
      |=> (!$stable(rd_addr_i) || (rd_data_o >= $past(rd_data_o))));
endmodule

bind rx_stat_bank rx_stat_bank_chk #(
  .LEN_W(LEN_W), .STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .frm_done_i(frm_done_i),
  .frm_len_i(frm_len_i), .long_en_i(long_en_i), .keep_bad_i(keep_bad_i),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .drop_o(drop_o)
);

// File: tb/rx_stat_bank_tb.sv
module rx_stat_bank_tb;
  localparam int PERIOD  = 10;
  localparam int LEN_W   = 16;
  localparam int CNT_W   = 8;
  localparam int OCT_W   = 24;
  localparam int WD_CYC  = 190000;
  localparam longint PKT_MAX = (64'd1 << CNT_W) - 1;
  localparam longint OCT_MAX = (64'd1 << OCT_W) - 1;

  typedef struct packed {
    logic [15:0] len;
    logic [1:0]  cls;
    logic        lng;
    logic        keep;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{16'd64,    2'b00, 1'b0, 1'b0},
    '{16'd63,    2'b10, 1'b0, 1'b0},
    '{16'd65,    2'b01, 1'b0, 1'b0},
    '{16'd127,   2'b00, 1'b0, 1'b0},
    '{16'd128,   2'b10, 1'b0, 1'b0},
    '{16'd255,   2'b01, 1'b0, 1'b0},
    '{16'd256,   2'b11, 1'b0, 1'b0},
    '{16'd511,   2'b00, 1'b0, 1'b0},
    '{16'd512,   2'b01, 1'b0, 1'b0},
    '{16'd1023,  2'b10, 1'b0, 1'b0},
    '{16'd1024,  2'b00, 1'b0, 1'b0},
    '{16'd1522,  2'b01, 1'b0, 1'b0},
    '{16'd1523,  2'b10, 1'b0, 1'b0},
    '{16'd1523,  2'b00, 1'b0, 1'b1},
    '{16'd1523,  2'b01, 1'b1, 1'b0},
    '{16'd16384, 2'b10, 1'b1, 1'b0},
    '{16'd16385, 2'b00, 1'b1, 1'b0},
    '{16'd16385, 2'b01, 1'b1, 1'b1},
    '{16'd9000,  2'b10, 1'b0, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr = 1'b0;
  logic              done = 1'b0;
  logic [LEN_W-1:0]  len = '0;
  logic [1:0]        cls = '0;
  logic              lng = 1'b0;
  logic              keep = 1'b0;
  logic [3:0]        addr = '0;
  logic [31:0]       rdata;
  logic              drop;

  int     n_chk = 0;
  int     n_fail = 0;
  longint m [15];
  longint toct, goct;

  always #(PERIOD/2) clk = ~clk;

  rx_stat_bank #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .frm_done_i(done),
    .frm_len_i(len), .frm_class_i(cls), .long_en_i(lng), .keep_bad_i(keep),
    .rd_addr_i(addr), .rd_data_o(rdata), .drop_o(drop)
  );

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic string req_of(input int a);
    if (a <= 5) return "R4 bin";
    if (a <= 7) return "R5 packets";
    if (a <= 11) return "R6 octets";
    if (a <= 13) return "R7 class";
    if (a == 14) return "R2 oversize";
    return "R10 unused";
  endfunction

  function automatic longint exp_rd(input int a);
    case (a)
      8:  return toct & 64'hFFFF_FFFF;
      9:  return toct >> 32;
      10: return goct & 64'hFFFF_FFFF;
      11: return goct >> 32;
      15: return 0;
      default: return m[a];
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 15; i++) m[i] = 0;
    toct = 0; goct = 0;
  endtask

  task automatic bump(input int i);
    if (m[i] < PKT_MAX) m[i]++;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      addr = 4'(a);
      #1;
      check($sformatf("%s %s addr %0d", req_of(a), tag, a), longint'(rdata), exp_rd(a));
    end
  endtask

  task automatic send(input logic [15:0] l, input logic [1:0] c,
                      input logic lg, input logic kb, input logic cl);
    logic ovr, drp;
    int b;
    @(negedge clk);
    len = l; cls = c; lng = lg; keep = kb; clr = cl; done = 1'b1;
    @(negedge clk);
    done = 1'b0; clr = 1'b0;
    ovr = (l > 16384) || (l > 1522 && !lg);
    drp = ovr && !kb;
    check($sformatf("R1/R2/R3 drop len %0d lng %0b keep %0b", l, lg, kb),
          longint'(drop), longint'(drp));
    if (cl) model_clear();
    else if (drp) bump(14);
    else begin
      b = -1;
      if (l == 64) b = 0;
      else if (l >= 65 && l <= 127) b = 1;
      else if (l >= 128 && l <= 255) b = 2;
      else if (l >= 256 && l <= 511) b = 3;
      else if (l >= 512 && l <= 1023) b = 4;
      else if (l > 1023) b = 5;
      if (b >= 0) bump(b);
      bump(6); bump(7);
      toct = (toct + l + 4 > OCT_MAX) ? OCT_MAX : toct + l + 4;
      goct = (goct + l + 4 > OCT_MAX) ? OCT_MAX : goct + l + 4;
      if (c == 2'b10) bump(12);
      if (c == 2'b01) bump(13);
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    // R11: reset state
    repeat (2) @(negedge clk);
    check("R11 drop in reset", longint'(drop), 0);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #1;
      check($sformatf("R11 reset addr %0d", a), longint'(rdata), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1..R7, R10
    for (int v = 0; v < NV; v++) begin
      send(VECS[v].len, VECS[v].cls, VECS[v].lng, VECS[v].keep, 1'b0);
      read_all($sformatf("vec %0d", v));
    end

    // R2: idle cycle leaves drop low
    @(negedge clk);
    check("R2 drop idle", longint'(drop), 0);

    // R9: clear together with a dropped frame strobe
    send(16'd20000, 2'b10, 1'b0, 1'b0, 1'b1);
    read_all("R9 clear with strobe");

    // R9: clear alone after some traffic
    send(16'd300, 2'b01, 1'b0, 1'b0, 1'b0);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; model_clear();
    read_all("R9 clear alone");

    // R8: packet counter saturation
    for (int i = 0; i < 300; i++) send(16'd64, 2'b00, 1'b0, 1'b0, 1'b0);
    read_all("R8 packet saturation");

    // R8: octet counter saturation, broadcast saturation
    for (int i = 0; i < 1100; i++) send(16'd16000, 2'b10, 1'b1, 1'b0, 1'b0);
    read_all("R8 octet saturation");

    // R8: oversize counter saturation
    for (int i = 0; i < 260; i++) send(16'd17000, 2'b01, 1'b1, 1'b0, 1'b0);
    read_all("R8 oversize saturation");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule